// File: doc/BRIEF.md
# Sweeping Quadrature Oscillator and Mixer

This block turns a stream of real 16-bit samples into complex baseband pairs for a decimating lowpass filter that follows it. Each accepted sample is multiplied by the cosine and by the negated sine of a numerically controlled phase. The products are rounded to 18 bits and appear as an in-phase and a quadrature output. A sample can be accepted on every clock cycle.

The oscillator has four modes. A steady tone keeps its frequency fixed. Hop mode swaps to a staged frequency when a hop request arrives, and the phase carries on without a jump. The two sweep modes ramp the frequency up or down by a signed rate on every sample. Configuration is staged first and applied at the next accepted sample. A clear input returns the phase to zero. A bypass bit routes the input to the in-phase output with a fixed gain and holds the quadrature output at zero, so the filter chain after it acts as a plain lowpass filter.

Top module: `nco_chirp_mixer`

## Requirements
- R1: With cfg_offset_bin = 1 the input word is read as offset binary: its bit 15 is inverted, giving two's complement. With cfg_offset_bin = 0 it is already two's complement. The bit is sampled together with each accepted sample.
- R2: Outside bypass, let x be the converted sample, P the top 10 bits of the 32-bit phase used for it, and a = 2*pi*P/1024. Then out_i = floor((x*C + 4096)/8192) and out_q = floor((-x*S + 4096)/8192), where C and S are cos(a) and sin(a) scaled by 32767 and rounded. Each output lies within 5 LSB of this value, and matches it exactly when P is a multiple of 256.
- R3: out_valid goes high exactly three cycles after each cycle with in_valid high, and only then. Back-to-back samples give back-to-back results.
- R4: The phase is 0 after reset. After each accepted sample it advances, modulo 2^32, by the effective frequency of that sample. It holds while in_valid is low.
- R5: Mode code 0 (tone): the frequency stays constant from sample to sample.
- R6: Mode code 2 (upward sweep): after each sample the frequency becomes the effective frequency plus the rate word, modulo 2^32.
- R7: Mode code 3 (downward sweep): after each sample the frequency becomes the effective frequency minus the rate word, modulo 2^32.
- R8: Mode code 1 (hop): a hop_req pulse makes the staged frequency the effective frequency at the next accepted sample. The phase is not reset. In any other mode hop_req has no effect.
- R9: A cfg_load pulse stages cfg_mode, cfg_freq and cfg_rate. At the next accepted sample, the staged mode and rate become active and the staged frequency becomes the effective frequency, unless the staged mode is hop, in which case the frequency waits for a hop. The sample that consumes the update still uses the phase already accumulated.
- R10: A phase_clr pulse sets the phase to 0 at the next edge, taking precedence over the advance. The first sample accepted after it uses phase 0.
- R11: With cfg_bypass = 1 on an accepted sample, its result has out_i = x*4 (x followed by two zero bits) and out_q = 0.
- R12: After reset: out_valid = 0, out_i = 0, out_q = 0, frequency 0, mode tone, nothing staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | 16 | Input sample |
| cfg_offset_bin | input | 1 | 1: input is offset binary |
| cfg_bypass | input | 1 | 1: skip oscillator and mixer for this sample |
| cfg_load | input | 1 | Stage mode, frequency and rate |
| cfg_mode | input | 2 | 0 tone, 1 hop, 2 upward sweep, 3 downward sweep |
| cfg_freq | input | 32 | Frequency word (phase step per sample) |
| cfg_rate | input | 32 | Sweep rate word, added or subtracted per sample |
| hop_req | input | 1 | Request switch to the staged frequency |
| phase_clr | input | 1 | Return phase to zero |
| out_valid | output | 1 | Result present |
| out_i | output | 18 | In-phase result, two's complement |
| out_q | output | 18 | Quadrature result, two's complement |

## Verification
A wrong phase or frequency register shows at the ports three cycles later, on the first sample that uses it, as I and Q values far outside the 5 LSB tolerance. Because the phase integrates the frequency, a frequency that is off by one step gives a phase error that grows with every later sample. Sweep and hop errors are therefore caught within a few samples of the faulty update. Phases that are multiples of a quarter turn give exact values, so a table, sign or quadrant error is caught on a single sample, and a latency error shows as a valid flag one cycle early or late.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

   typedef enum logic [1:0] {
      MODE_TONE = 2'd0,
      MODE_HOP  = 2'd1,
      MODE_UP   = 2'd2,
      MODE_DOWN = 2'd3
   } nco_mode_e;

   // Quarter-wave entry k of qn: amp * sin(pi/2 * k/qn), odd Taylor series in Q30.
   function automatic int quarter_sine(int k, int qn, int amp);
      longint x, x2, term, sum, v;
      x    = (64'sd1686629713 * longint'(k)) / longint'(qn);
      x2   = (x * x) >>> 30;
      term = x;
      sum  = x;
      for (int n = 1; n <= 7; n++) begin
         term = -(((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1)));
         sum  = sum + term;
      end
      v = (sum * longint'(amp) + (64'sd1 <<< 29)) >>> 30;
      if (v > longint'(amp)) v = longint'(amp);
      if (v < 0) v = 0;
      return int'(v);
   endfunction

endpackage

// File: rtl/nco_phase_ctl.sv
module nco_phase_ctl
   import nco_mix_pkg::*;
#(
   parameter int PH_W = 32,
   parameter int TA   = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            cfg_load,
   input  nco_mode_e       cfg_mode,
   input  logic [PH_W-1:0] cfg_freq,
   input  logic [PH_W-1:0] cfg_rate,
   input  logic            hop_req,
   input  logic            phase_clr,
   output logic [TA-1:0]   phase_top
);

   nco_mode_e       mode_a, mode_p, m_eff;
   logic [PH_W-1:0] phase, freq_a, rate_a, freq_p, rate_p;
   logic [PH_W-1:0] f_eff, r_eff, f_next;
   logic            upd_pend, hop_pend;

   always_comb begin
      f_eff = freq_a;
      r_eff = rate_a;
      m_eff = mode_a;
      if (upd_pend) begin
         m_eff = mode_p;
         r_eff = rate_p;
         if (mode_p != MODE_HOP) f_eff = freq_p;
      end else if (hop_pend && mode_a == MODE_HOP) begin
         f_eff = freq_p;
      end
      unique case (m_eff)
         MODE_UP:   f_next = f_eff + r_eff;
         MODE_DOWN: f_next = f_eff - r_eff;
         default:   f_next = f_eff;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= '0;
         freq_a   <= '0;
         rate_a   <= '0;
         mode_a   <= MODE_TONE;
         freq_p   <= '0;
         rate_p   <= '0;
         mode_p   <= MODE_TONE;
         upd_pend <= 1'b0;
         hop_pend <= 1'b0;
      end else begin
         if (in_valid) begin
            phase    <= phase + f_eff;
            freq_a   <= f_next;
            rate_a   <= r_eff;
            mode_a   <= m_eff;
            upd_pend <= 1'b0;
            hop_pend <= 1'b0;
         end
         if (phase_clr) phase <= '0;
         if (cfg_load) begin
            mode_p   <= cfg_mode;
            freq_p   <= cfg_freq;
            rate_p   <= cfg_rate;
            upd_pend <= 1'b1;
         end
         if (hop_req) hop_pend <= 1'b1;
      end
   end

   assign phase_top = phase[PH_W-1 -: TA];

   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      phase_clr |=> phase == '0);
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !phase_clr) |=> $stable(phase));
   a_r5_tone_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !upd_pend && mode_a == MODE_TONE) |=> $stable(freq_a));
   a_r6_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !upd_pend && mode_a == MODE_UP)
      |=> freq_a == $past(freq_a) + $past(rate_a));
   a_r7_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !upd_pend && mode_a == MODE_DOWN)
      |=> freq_a == $past(freq_a) - $past(rate_a));
   a_r8_hop_load: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !upd_pend && hop_pend && mode_a == MODE_HOP)
      |=> freq_a == $past(freq_p));
   a_r9_mode_apply: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && upd_pend) |=> mode_a == $past(mode_p));

endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
   parameter int LA    = 8,
   parameter int SIN_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic [LA+1:0]           addr,
   output logic signed [SIN_W-1:0] cos_o,
   output logic signed [SIN_W-1:0] sin_o
);

   localparam int QN  = 1 << LA;
   localparam int AMP = (1 << (SIN_W - 1)) - 1;

   logic [SIN_W-1:0] tab [QN+1];

   for (genvar k = 0; k <= QN; k++) begin : g_tab
      localparam int VAL = nco_mix_pkg::quarter_sine(k, QN, AMP);
      assign tab[k] = SIN_W'(VAL);
   end

   logic [1:0]              quad;
   logic [LA:0]             fwd, rev;
   logic signed [SIN_W-1:0] a_f, a_r, s_n, c_n;

   assign quad = addr[LA+1:LA];
   assign fwd  = {1'b0, addr[LA-1:0]};
   assign rev  = (LA+1)'(QN) - fwd;
   assign a_f  = signed'(tab[fwd]);
   assign a_r  = signed'(tab[rev]);

   always_comb begin
      unique case (quad)
         2'd0:    begin s_n =  a_f; c_n =  a_r; end
         2'd1:    begin s_n =  a_r; c_n = -a_f; end
         2'd2:    begin s_n = -a_f; c_n = -a_r; end
         default: begin s_n = -a_r; c_n =  a_f; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cos_o <= '0;
         sin_o <= '0;
      end else if (en) begin
         cos_o <= c_n;
         sin_o <= s_n;
      end
   end

   a_r2_zero_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (en && addr == '0) |=> (cos_o == SIN_W'(AMP) && sin_o == '0));
   a_r2_quarter_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (en && addr == (LA+2)'(QN)) |=> (sin_o == SIN_W'(AMP) && cos_o == '0));

endmodule

// File: rtl/nco_mixer.sv
module nco_mixer #(
   parameter int IN_W       = 16,
   parameter int SIN_W      = 16,
   parameter int OUT_W      = 18,
   parameter bit ROUND_NEAR = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    byp,
   input  logic signed [IN_W-1:0]  x,
   input  logic signed [SIN_W-1:0] c,
   input  logic signed [SIN_W-1:0] s,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_i,
   output logic signed [OUT_W-1:0] out_q
);

   localparam int PW     = IN_W + SIN_W;
   localparam int SH     = PW - OUT_W - 1;
   localparam int BYP_SH = OUT_W - IN_W;

   logic signed [PW-1:0] p_i, p_q, rnd, r_i, r_q;

   if (ROUND_NEAR) begin : g_rnd_near
      assign rnd = PW'(1) <<< (SH - 1);
   end else begin : g_rnd_trunc
      assign rnd = '0;
   end

   assign p_i = x * c;
   assign p_q = -(x * s);
   assign r_i = (p_i + rnd) >>> SH;
   assign r_q = (p_q + rnd) >>> SH;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= en;
         if (en) begin
            if (byp) begin
               out_i <= {x, {BYP_SH{1'b0}}};
               out_q <= '0;
            end else begin
               out_i <= OUT_W'(r_i);
               out_q <= OUT_W'(r_q);
            end
         end
      end
   end

   a_r11_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (en && byp) |=> (out_q == '0 && out_i == OUT_W'($past(x)) <<< BYP_SH));

endmodule

// File: rtl/nco_chirp_mixer.sv
module nco_chirp_mixer
   import nco_mix_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int SIN_W = 16,
   parameter int OUT_W = 18,
   parameter int PH_W  = 32,
   parameter int LA    = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [IN_W-1:0]         in_data,
   input  logic                    cfg_offset_bin,
   input  logic                    cfg_bypass,
   input  logic                    cfg_load,
   input  logic [1:0]              cfg_mode,
   input  logic [PH_W-1:0]         cfg_freq,
   input  logic [PH_W-1:0]         cfg_rate,
   input  logic                    hop_req,
   input  logic                    phase_clr,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] out_i,
   output logic signed [OUT_W-1:0] out_q
);

   localparam int TA = LA + 2;
   localparam int SH = IN_W + SIN_W - OUT_W - 1;

   if (SH < 1) begin : g_bad_shift
      $error("OUT_W too wide for the product width");
   end
   if (OUT_W < IN_W) begin : g_bad_out
      $error("OUT_W must be at least IN_W");
   end
   if (PH_W < TA) begin : g_bad_phase
      $error("PH_W must cover the table address");
   end

   logic [TA-1:0]           ph_top, ph1;
   logic signed [IN_W-1:0]  x_in, x1, x2;
   logic                    v1, v2, byp1, byp2;
   logic signed [SIN_W-1:0] cos_v, sin_v;

   nco_phase_ctl #(.PH_W(PH_W), .TA(TA)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .cfg_load  (cfg_load),
      .cfg_mode  (nco_mode_e'(cfg_mode)),
      .cfg_freq  (cfg_freq),
      .cfg_rate  (cfg_rate),
      .hop_req   (hop_req),
      .phase_clr (phase_clr),
      .phase_top (ph_top)
   );

   assign x_in = signed'({in_data[IN_W-1] ^ cfg_offset_bin, in_data[IN_W-2:0]});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1   <= 1'b0;
         v2   <= 1'b0;
         x1   <= '0;
         x2   <= '0;
         ph1  <= '0;
         byp1 <= 1'b0;
         byp2 <= 1'b0;
      end else begin
         v1 <= in_valid;
         v2 <= v1;
         if (in_valid) begin
            x1   <= x_in;
            ph1  <= ph_top;
            byp1 <= cfg_bypass;
         end
         if (v1) begin
            x2   <= x1;
            byp2 <= byp1;
         end
      end
   end

   nco_sincos_rom #(.LA(LA), .SIN_W(SIN_W)) u_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (v1),
      .addr  (ph1),
      .cos_o (cos_v),
      .sin_o (sin_v)
   );

   nco_mixer #(.IN_W(IN_W), .SIN_W(SIN_W), .OUT_W(OUT_W), .ROUND_NEAR(1'b1)) u_mix (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (v2),
      .byp       (byp2),
      .x         (x2),
      .c         (cos_v),
      .s         (sin_v),
      .out_valid (out_valid),
      .out_i     (out_i),
      .out_q     (out_q)
   );

   // Independent shadow of the accepted-sample stream for the latency check.
   logic [2:0] shadow_v;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow_v <= '0;
      else        shadow_v <= {shadow_v[1:0], in_valid};
   end

   a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == shadow_v[2]);
   a_r1_offset_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_offset_bin) |=> x1[IN_W-1] == !$past(in_data[IN_W-1]));

endmodule

// File: tb/nco_chirp_mixer_tb.sv
module nco_chirp_mixer_tb;

   localparam int NCYC = 16384;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic [15:0]        in_data = '0;
   logic               cfg_offset_bin = 1'b0;
   logic               cfg_bypass = 1'b0;
   logic               cfg_load = 1'b0;
   logic [1:0]         cfg_mode = '0;
   logic [31:0]        cfg_freq = '0;
   logic [31:0]        cfg_rate = '0;
   logic               hop_req = 1'b0;
   logic               phase_clr = 1'b0;
   logic               out_valid;
   logic signed [17:0] out_i, out_q;

   nco_chirp_mixer u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .cfg_offset_bin(cfg_offset_bin), .cfg_bypass(cfg_bypass), .cfg_load(cfg_load),
      .cfg_mode(cfg_mode), .cfg_freq(cfg_freq), .cfg_rate(cfg_rate),
      .hop_req(hop_req), .phase_clr(phase_clr),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
   );

   always #4ns clk = ~clk;

   int    cyc = 0;
   int    checks = 0;
   int    fails = 0;
   bit    done = 1'b0;
   bit    run_chk = 1'b0;
   string tag = "R2";

   bit    exp_v [NCYC];
   int    exp_i [NCYC];
   int    exp_q [NCYC];
   int    exp_t [NCYC];
   string exp_g [NCYC];

   // Reference model state, kept from the requirements.
   bit [31:0] m_phase = '0, m_freq = '0, m_rate = '0, p_freq = '0, p_rate = '0;
   bit [1:0]  m_mode = 2'd0, p_mode = 2'd0;
   bit        m_upd = 1'b0, m_hop = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (run_chk && cyc < NCYC) begin
         if (exp_v[cyc] || out_valid) begin
            checks++;
            if (exp_v[cyc] != out_valid) begin
               fails++;
               $display("FAIL R3 cycle %0d: out_valid=%0b expected %0b", cyc, out_valid, exp_v[cyc]);
            end else if ((int'(out_i) - exp_i[cyc] > exp_t[cyc]) || (exp_i[cyc] - int'(out_i) > exp_t[cyc]) ||
                         (int'(out_q) - exp_q[cyc] > exp_t[cyc]) || (exp_q[cyc] - int'(out_q) > exp_t[cyc])) begin
               fails++;
               $display("FAIL %s cycle %0d: i=%0d q=%0d expected i=%0d q=%0d (tol %0d)",
                        exp_g[cyc], cyc, out_i, out_q, exp_i[cyc], exp_q[cyc], exp_t[cyc]);
            end
         end
      end
   end

   task automatic step(bit v, int x, bit ob, bit by, bit ld, bit [1:0] md,
                       bit [31:0] fw, bit [31:0] rw, bit hp, bit cl);
      bit [31:0] fe, re;
      bit [1:0]  me;
      bit [9:0]  t;
      int        c, s, e;
      real       a;
      longint    pr;
      in_valid       = v;
      in_data        = ob ? (16'(x) ^ 16'h8000) : 16'(x);
      cfg_offset_bin = ob;
      cfg_bypass     = by;
      cfg_load       = ld;
      cfg_mode       = md;
      cfg_freq       = fw;
      cfg_rate       = rw;
      hop_req        = hp;
      phase_clr      = cl;
      if (v) begin
         e = cyc + 3;
         t = m_phase[31:22];
         exp_v[e] = 1'b1;
         exp_g[e] = by ? "R11" : tag;
         if (by) begin
            exp_i[e] = x * 4;
            exp_q[e] = 0;
            exp_t[e] = 0;
         end else begin
            a  = 6.283185307179586 * real'(t) / 1024.0;
            c  = int'(32767.0 * $cos(a));
            s  = int'(32767.0 * $sin(a));
            pr = longint'(x) * longint'(c);
            exp_i[e] = int'((pr + 4096) >>> 13);
            pr = -(longint'(x) * longint'(s));
            exp_q[e] = int'((pr + 4096) >>> 13);
            exp_t[e] = (t[7:0] == 8'd0) ? 0 : 5;
         end
         fe = m_freq; re = m_rate; me = m_mode;
         if (m_upd) begin
            me = p_mode; re = p_rate;
            if (p_mode != 2'd1) fe = p_freq;
         end else if (m_hop && m_mode == 2'd1) begin
            fe = p_freq;
         end
         m_phase = m_phase + fe;
         m_freq  = (me == 2'd2) ? fe + re : (me == 2'd3) ? fe - re : fe;
         m_rate  = re;
         m_mode  = me;
         m_upd   = 1'b0;
         m_hop   = 1'b0;
      end
      if (cl) m_phase = '0;
      if (ld) begin
         p_mode = md; p_freq = fw; p_rate = rw; m_upd = 1'b1;
      end
      if (hp) m_hop = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic load(bit [1:0] md, bit [31:0] fw, bit [31:0] rw);
      step(0, 0, 0, 0, 1, md, fw, rw, 0, 0);
   endtask

   function automatic int rnd_x();
      return int'($urandom_range(65535)) - 32768;
   endfunction

   task automatic burst(int n, int pct);
      for (int k = 0; k < n; k++)
         step(($urandom % 100) < pct, rnd_x(), $urandom % 2, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic chk_eq(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, expv);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R12: reset state
      chk_eq("R12 out_valid", int'(out_valid), 0);
      chk_eq("R12 out_i", int'(out_i), 0);
      chk_eq("R12 out_q", int'(out_q), 0);
      rst_n = 1'b1;
      run_chk = 1'b1;
      idle(2);

      // R1/R12: frequency 0 after reset, phase 0, full-scale and both formats
      tag = "R1";
      step(1, 32767, 0, 0, 0, 0, 0, 0, 0, 0);
      step(1, -32768, 0, 0, 0, 0, 0, 0, 0, 0);
      step(1, 32767, 1, 0, 0, 0, 0, 0, 0, 0);
      step(1, -32768, 1, 0, 0, 0, 0, 0, 0, 0);
      step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      step(1, -1, 1, 0, 0, 0, 0, 0, 0, 0);
      idle(4);

      // R2: quarter-turn steps give exact values
      tag = "R2";
      load(2'd0, 32'h4000_0000, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      for (int k = 0; k < 8; k++) step(1, 12345, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 8; k++) step(1, -32768, 1, 0, 0, 0, 0, 0, 0, 0);
      idle(4);

      // R3/R4/R5: random tone, gaps hold the phase
      tag = "R5";
      load(2'd0, $urandom, 0);
      burst(200, 70);
      tag = "R3";
      burst(100, 100);
      idle(4);

      // R6: upward sweep, with hop pulses that must be ignored (R8)
      tag = "R6";
      load(2'd2, $urandom, 32'h0001_0000 + ($urandom % 32'h0100_0000));
      for (int k = 0; k < 200; k++)
         step(($urandom % 4) != 0, rnd_x(), 0, 0, 0, 0, 0, 0, (k % 37) == 5, 0);
      // R7: downward sweep
      tag = "R7";
      load(2'd3, $urandom, $urandom % 32'h0200_0000);
      burst(200, 80);
      idle(4);

      // R8: hop with continuous phase
      tag = "R8";
      load(2'd0, 32'h0123_4567, 0);
      burst(20, 100);
      load(2'd1, 32'h3456_789A, 0);
      burst(20, 100);
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
      burst(30, 100);
      load(2'd1, 32'h0765_4321, 0);
      burst(10, 100);
      step(1, rnd_x(), 0, 0, 0, 0, 0, 0, 1, 0);
      burst(30, 90);
      idle(4);

      // R9: loads coincident with samples and during gaps
      tag = "R9";
      for (int k = 0; k < 300; k++)
         step(($urandom % 3) != 0, rnd_x(), $urandom % 2, 0, ($urandom % 9) == 0,
              2'($urandom % 4), $urandom, $urandom % 32'h0400_0000, ($urandom % 11) == 0, 0);
      idle(4);

      // R10: clear
      tag = "R10";
      load(2'd0, 32'h1357_9BDF, 0);
      burst(15, 100);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      burst(15, 100);
      step(1, 30000, 0, 0, 0, 0, 0, 0, 0, 1);
      step(1, 30000, 0, 0, 0, 0, 0, 0, 0, 0);
      burst(10, 100);
      idle(4);

      // R11: bypass, both input formats, interleaved with mixed samples
      tag = "R2";
      step(1, -32768, 0, 1, 0, 0, 0, 0, 0, 0);
      step(1, 32767, 1, 1, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 100; k++)
         step(($urandom % 5) != 0, rnd_x(), $urandom % 2, ($urandom % 2) == 0, 0, 0, 0, 0, 0, 0);
      idle(4);

      // Random mix of everything
      tag = "R4";
      for (int k = 0; k < 1500; k++)
         step(($urandom % 4) != 0, rnd_x(), $urandom % 2, ($urandom % 8) == 0,
              ($urandom % 40) == 0, 2'($urandom % 4), $urandom, $urandom,
              ($urandom % 25) == 0, ($urandom % 90) == 0);
      idle(6);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, cycle %0d expected below %0d", cyc, 40000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule